// File: doc/BRIEF.md
# Specific-Gravity Network Inference Engine

This block evaluates a small fixed feed-forward neural network that turns five battery measurements into one estimate of electrolyte specific gravity. A later stage maps that estimate to a state-of-charge class. The network has five inputs, two hidden layers of eleven neurons each, and one output neuron. A single multiply-accumulate datapath is shared across the whole network and steps through every weight in turn, one per enabled clock cycle.

Weights and biases sit in an internal register array. This array is loaded through a simple address/data write port while the engine is idle. All values are signed fixed point with eight fraction bits (1.0 is 256). An inference starts only when a start request arrives and both the consumption-time and current inputs are nonzero. Until the next inference completes, the previous estimate stays on the output.

Top module: `sg_mlp_engine`

## Requirements
- R1: While reset is asserted and on release, `busy`, `done` and `sg_valid` are 0 and `sg_out` is 0.
- R2: An inference is launched only on a rising edge where `enable`, `start` and not `busy` all hold and both `in_time` and `in_current` are nonzero. Any other start request leaves `busy` low and `sg_out` unchanged.
- R3: With `enable` held high, `done` pulses for exactly one cycle. It is visible after the 210th rising edge following the launch edge, and `busy` falls in the same cycle.
- R4: While `busy` is high and `enable` is low, the sequence stalls: no progress is made, and `done` stays low.
- R5: Each neuron sums weight×input products into a Q16.16 accumulator that saturates at 32 bits, then adds its bias scaled by 256 (also saturating). The sum is shifted right arithmetically by 8 and saturated to 16 bits.
- R6: Hidden-layer results are clamped to the range [-256, +256]. The output neuron result is not clamped.
- R7: The weight array holds 210 words, each neuron's weights followed by its bias. First-layer neuron n uses words 6n..6n+5, with input order time, current, voltage, temperature, resistance. Second-layer neuron n uses words 66+12n..66+12n+11, weight j taken against first-layer neuron j. The output neuron uses words 198..209, weight j taken against second-layer neuron j, with its bias at 209.
- R8: A write is ignored while `busy` is high, and a write to an address of 210 or above is ignored.
- R9: `sg_out` and `sg_valid` change only in a cycle where `done` is high. Input values are captured at launch, so later changes do not affect the result.
- R10: A start request while `busy` is high is ignored and does not restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows launch and stepping when 1 |
| start | input | 1 | Request a new inference |
| in_time | input | 16 | Consumption time, signed Q8.8 |
| in_current | input | 16 | Current drawn, signed Q8.8 |
| in_voltage | input | 16 | Terminal voltage, signed Q8.8 |
| in_temp | input | 16 | Temperature, signed Q8.8 |
| in_resist | input | 16 | Internal resistance, signed Q8.8 |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | 8 | Weight word address |
| wr_data | input | 16 | Weight or bias value, signed Q8.8 |
| busy | output | 1 | Inference in progress |
| done | output | 1 | One-cycle completion pulse |
| sg_out | output | 16 | Specific-gravity estimate, signed Q8.8 |
| sg_valid | output | 1 | An estimate has been produced since reset |

## Verification
The embedded assertions check the following on every cycle: the single-cycle shape of `done`, that `busy` drops with it, the stall under a low `enable`, the launch condition, that the output is held between completions, and the hidden activation range. Only the bench scenarios can show that the numbers are right. These scenarios cover the exact 210-cycle latency, the weight address layout, the clamping, and the rounding and saturation of the sum. They also show that writes and start requests arriving mid-run have no effect. The bench does this by comparing every cycle against a behavioural fixed-point model, using random weights, random input changes and random enable gaps.

// File: rtl/sg_mlp_engine.sv
module sg_mlp_engine #(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int ACCW  = 32,
  parameter int N_IN  = 5,
  parameter int N_HID = 11,
  parameter int AW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 start,
  input  logic signed [DW-1:0] in_time,
  input  logic signed [DW-1:0] in_current,
  input  logic signed [DW-1:0] in_voltage,
  input  logic signed [DW-1:0] in_temp,
  input  logic signed [DW-1:0] in_resist,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] sg_out,
  output logic                 sg_valid
);
  localparam int L1_SPAN  = N_IN + 1;
  localparam int L2_SPAN  = N_HID + 1;
  localparam int OUT_BASE = N_HID * L1_SPAN + N_HID * L2_SPAN;
  localparam int NWORDS   = OUT_BASE + L2_SPAN;
  localparam int IW       = $clog2(N_HID + 2);
  localparam int ONE      = 1 << FRAC;
  localparam logic signed [ACCW-1:0] ACC_MAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] ACC_MIN = {1'b1, {(ACCW-1){1'b0}}};
  localparam logic signed [DW-1:0]   OUT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0]   OUT_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0]   wmem [NWORDS];
  logic signed [DW-1:0]   xin  [N_IN];
  logic signed [DW-1:0]   h1   [N_HID];
  logic signed [DW-1:0]   h2   [N_HID];
  logic [1:0]             layer;
  logic [IW-1:0]          k, nrn;
  logic [AW-1:0]          addr;
  logic signed [ACCW-1:0] acc;

  logic                   bias_cyc;
  logic signed [DW-1:0]   w, op, narrow, act;
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] addend, acc_next, shifted;
  logic [ACCW:0]          sum_w;
  logic [ACCW-DW:0]       hi;

  assign bias_cyc = (k == IW'(layer == 2'd0 ? N_IN : N_HID));
  assign w        = wmem[addr];

  always_comb begin
    op = '0;
    for (int j = 0; j < N_IN; j++)
      if (layer == 2'd0 && k == IW'(j)) op = xin[j];
    for (int j = 0; j < N_HID; j++) begin
      if (layer == 2'd1 && k == IW'(j)) op = h1[j];
      if (layer == 2'd2 && k == IW'(j)) op = h2[j];
    end
  end

  assign prod    = w * op;
  assign addend  = bias_cyc ? (ACCW'(w) <<< FRAC) : ACCW'(prod);
  assign sum_w   = {acc[ACCW-1], acc} + {addend[ACCW-1], addend};
  assign acc_next = (sum_w[ACCW] != sum_w[ACCW-1]) ? (sum_w[ACCW] ? ACC_MIN : ACC_MAX)
                                                   : sum_w[ACCW-1:0];
  assign shifted = acc_next >>> FRAC;
  assign hi      = shifted[ACCW-1:DW-1];
  assign narrow  = (hi == '0 || hi == '1) ? shifted[DW-1:0]
                                          : (shifted[ACCW-1] ? OUT_MIN : OUT_MAX);

  always_comb begin
    act = narrow;
    if (layer != 2'd2) begin
      if (narrow > DW'(ONE))       act = DW'(ONE);
      else if (narrow < -DW'(ONE)) act = -DW'(ONE);
    end
  end

  always_ff @(posedge clk)
    if (wr_en && !busy && int'(wr_addr) < NWORDS) wmem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; sg_out <= '0; sg_valid <= 1'b0;
      layer <= '0; k <= '0; nrn <= '0; addr <= '0; acc <= '0;
      for (int j = 0; j < N_IN; j++) xin[j] <= '0;
      for (int j = 0; j < N_HID; j++) begin h1[j] <= '0; h2[j] <= '0; end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (enable && start && in_time != '0 && in_current != '0) begin
          busy <= 1'b1; layer <= '0; k <= '0; nrn <= '0; addr <= '0; acc <= '0;
          xin[0] <= in_time;  xin[1] <= in_current; xin[2] <= in_voltage;
          xin[3] <= in_temp;  xin[4] <= in_resist;
        end
      end else if (enable) begin
        addr <= addr + 1'b1;
        if (!bias_cyc) begin
          acc <= acc_next;
          k   <= k + 1'b1;
        end else begin
          acc <= '0;
          k   <= '0;
          case (layer)
            2'd0: begin
              h1[nrn] <= act;
              if (nrn == IW'(N_HID-1)) begin layer <= 2'd1; nrn <= '0; end
              else nrn <= nrn + 1'b1;
            end
            2'd1: begin
              h2[nrn] <= act;
              if (nrn == IW'(N_HID-1)) begin layer <= 2'd2; nrn <= '0; end
              else nrn <= nrn + 1'b1;
            end
            default: begin
              sg_out <= act; sg_valid <= 1'b1; done <= 1'b1; busy <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> ($stable(addr) && $stable(acc) && busy && !done));
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && start && in_time != '0 && in_current != '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sg_out) || $rose(sg_valid)) |-> done);

  for (genvar g = 0; g < N_HID; g++) begin : g_rng
    // R6
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h1[g] <= DW'(ONE) && h1[g] >= -DW'(ONE) && h2[g] <= DW'(ONE) && h2[g] >= -DW'(ONE)));
  end
endmodule

// File: tb/test_sg_mlp_engine.sv
module test_sg_mlp_engine;
  localparam int NW = 210;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, st = 1'b0, wr_en = 1'b0;
  logic signed [15:0] t = '0, c = '0, v = '0, tp = '0, r = '0, wr_data = '0;
  logic [7:0] wr_addr = '0;
  logic busy, done, sg_valid;
  logic signed [15:0] sg_out;
  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0;

  int m_w [NW];
  int mx [5];
  bit m_busy = 0, m_done = 0, m_valid = 0;
  int m_cnt = 0, m_out = 0;

  always #5 clk = ~clk;

  sg_mlp_engine i_sg_mlp_engine (
    .clk(clk), .rst_n(rst_n), .enable(en), .start(st),
    .in_time(t), .in_current(c), .in_voltage(v), .in_temp(tp), .in_resist(r),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .sg_out(sg_out), .sg_valid(sg_valid));

  function automatic longint sat(longint x, longint lo, longint hi);
    return x < lo ? lo : (x > hi ? hi : x);
  endfunction

  function automatic int neuron(int base, int fan, int src []);
    longint a = 0;
    longint n;
    for (int i = 0; i < fan; i++)
      a = sat(a + longint'(m_w[base+i]) * src[i], -64'sd2147483648, 64'sd2147483647);
    a = sat(a + longint'(m_w[base+fan]) * 256, -64'sd2147483648, 64'sd2147483647);
    n = sat(a >>> 8, -32768, 32767);
    return int'(n);
  endfunction

  function automatic int infer();
    int x [] = new[5];
    int h1 [] = new[11];
    int h2 [] = new[11];
    for (int i = 0; i < 5; i++) x[i] = mx[i];
    for (int n = 0; n < 11; n++) h1[n] = int'(sat(neuron(6*n, 5, x), -256, 256));
    for (int n = 0; n < 11; n++) h2[n] = int'(sat(neuron(66 + 12*n, 11, h1), -256, 256));
    return neuron(198, 11, h2);
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_valid = 0; m_out = 0; m_cnt = 0;
    end else begin
      if (wr_en && !m_busy && int'(wr_addr) < NW) m_w[wr_addr] = int'(wr_data);
      m_done = 0;
      if (m_busy) begin
        if (en) begin
          m_cnt++;
          if (m_cnt == NW) begin
            m_busy = 0; m_done = 1; m_out = infer(); m_valid = 1;
          end
        end
      end else if (en && st && t != 0 && c != 0) begin
        m_busy = 1; m_cnt = 0;
        mx[0] = int'(t); mx[1] = int'(c); mx[2] = int'(v); mx[3] = int'(tp); mx[4] = int'(r);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on) begin
    check(busy == m_busy, "R3 R10 busy", int'(busy), int'(m_busy));
    check(done == m_done, "R3 R4 done", int'(done), int'(m_done));
    check(sg_valid == m_valid, "R9 valid", int'(sg_valid), int'(m_valid));
    check(int'(sg_out) == m_out, "R5 R9 sg_out", int'(sg_out), m_out);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic launch(int tt, int cc, int vv, int tpp, int rr);
    t = 16'(tt); c = 16'(cc); v = 16'(vv); tp = 16'(tpp); r = 16'(rr);
    en = 1'b1; st = 1'b1;
    @(negedge clk);
    st = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  task automatic directed(int tt, int expv, string req);
    int lat;
    launch(tt, 1, 0, 0, 0);
    wait_done(lat);
    check(lat == NW, "R3 latency", lat, NW);
    check(int'(sg_out) == expv, req, int'(sg_out), expv);
  endtask

  initial begin
    int lat;
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 busy/done", int'(busy) + int'(done), 0);
    check(sg_valid == 0, "R1 valid", int'(sg_valid), 0);
    check(sg_out == 0, "R1 sg_out", int'(sg_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    check(busy == 0 && sg_valid == 0, "R1 after release", int'(busy), 0);

    for (int a = 0; a < NW; a++) wr(a, 0);
    wr(0, 256); wr(66, 256); wr(198, 512); wr(209, 128);
    // R7 layout: 0.5 passes through two unclamped layers: 2*0.5+0.5
    directed(128, 384, "R7 R5 chain");
    // R6 hidden clamp positive and negative
    directed(1024, 640, "R6 clamp high");
    directed(-1024, -384, "R6 clamp low");

    // R2 start ignored with zero current, and with enable low
    held = int'(sg_out);
    launch(300, 0, 0, 0, 0);
    check(busy == 0, "R2 zero current", int'(busy), 0);
    en = 1'b0; t = 16'd5; c = 16'd5; st = 1'b1;
    @(negedge clk);
    st = 1'b0;
    check(busy == 0 && int'(sg_out) == held, "R2 enable low", int'(sg_out), held);

    // R8 out-of-range write and write while busy have no effect
    wr(210, 1000); wr(255, 1000);
    launch(-1024, 1, 0, 0, 0);
    wr(209, 16'h7000);
    wait_done(lat);
    check(int'(sg_out) == -384, "R8 write during run", int'(sg_out), -384);
    directed(-1024, -384, "R8 bias kept");

    // R4 stall with enable low mid-run
    launch(128, 1, 0, 0, 0);
    repeat (20) @(negedge clk);
    en = 1'b0;
    repeat (300) @(negedge clk);
    check(busy == 1 && done == 0, "R4 stalled", int'(busy), 1);
    en = 1'b1;
    wait_done(lat);
    check(int'(sg_out) == 384, "R4 resume result", int'(sg_out), 384);

    // random weights, random enable gaps, input changes and restarts mid-run
    for (int run = 0; run < 10; run++) begin
      if (run % 3 == 0)
        for (int a = 0; a < NW; a++) wr(a, int'($urandom_range(600)) - 300);
      launch(int'($urandom_range(1023)) - 512 | 1, int'($urandom_range(255)) + 1,
             int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512,
             int'($urandom_range(1023)) - 512);
      lat = 0;
      while (!done && lat < 5000) begin
        en = ($urandom_range(3) != 0);
        st = m_busy && ($urandom_range(7) == 0);          // R10 stray starts
        t  = 16'(int'($urandom_range(1023)) - 512);        // R9 inputs move
        c  = 16'(int'($urandom_range(1023)) - 512);
        if ($urandom_range(5) == 0) wr(int'($urandom_range(209)), 16'h1234); // R8
        else @(negedge clk);
        lat++;
      end
      st = 1'b0; en = 1'b1;
      check(int'(sg_out) == m_out, "R5 random run", int'(sg_out), m_out);
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule